// File: doc/BRIEF.md
# Parallel Disk Register Target

This block is the device side of a legacy parallel disk register interface, seen by a host that polls or takes interrupts. The host reaches eight byte-wide registers in a command window through a 3-bit offset, plus a write-only control register on its own select. It loads a sector count, a 28-bit block address and a drive/head byte, then writes a command code. The block answers with a status byte whose BUSY, READY and DRQ bits follow the usual handshake order, an error byte, and an interrupt line.

Sector data moves through a 32-bit data port: 128 accesses per 512-byte sector. Written sectors land in an internal one-sector buffer. A read command returns the buffer contents, so the data the host reads back is the last sector it wrote. Each sector costs a fixed, parameterised service delay during which BUSY is set. The interrupt fires once per sector when the control register leaves it unmasked.

Top module: `dskreg_target`

## Requirements
- R1: After reset, status reads 0x40, error reads 0x00, sector count and address bytes read 0x00, the drive/head register reads 0xA0, and irq is low.
- R2: Offsets 2 (sector count), 3, 4 and 5 (address bits 7:0, 15:8, 23:16) read back the byte last written. Offset 6 keeps bit 6 (address mode), bit 4 (drive select) and bits 3:0 (address bits 27:24), and always reads bits 7 and 5 as 1.
- R3: A read command (0x20 written to offset 7 while idle) makes status 0x80 (BUSY set, READY clear) for exactly SVC_DELAY cycles, then 0x48 (READY and DRQ).
- R4: A write command (0x30 written to offset 7 while idle) gives status 0x48 from the very next cycle, with no BUSY phase.
- R5: A sector is 128 data-port accesses at offset 0. After the 128th read, DRQ drops. After the 128th write, status is 0x80 for exactly SVC_DELAY cycles before the next sector's DRQ or idle 0x40.
- R6: Words written during write DRQ are returned in the same order by a later read command. Data-port writes outside write DRQ are ignored.
- R7: The sector count sets how many sectors a command moves, and a count of 0 means 256 sectors. The command ends with status 0x40 after the last sector.
- R8: With control bit 1 clear, irq rises once per sector: when read data becomes available, when a written sector has been committed, or on an abort. With control bit 1 set, irq never rises.
- R9: A read of status (offset 7) clears irq at the following clock edge.
- R10: Any command code other than 0x20 or 0x30 sets status 0x41 (READY and ERROR, BUSY and DRQ clear), sets error to 0x04 (the abort bit, bit 2), and raises irq. The next accepted command clears the error.
- R11: Setting control bit 2 (soft reset) forces status 0x80 from the second cycle on, and clears error, DRQ and irq. Clearing it returns status to 0x40 two cycles after the control write.
- R12: Command writes while BUSY or DRQ is set are ignored, and so are read-command data accesses beyond the sector in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_cmd | input | 1 | Selects the eight-register command window |
| cs_ctl | input | 1 | Selects the control register (write only) |
| addr | input | 3 | Register offset within the command window |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe; side effects happen at the clock edge |
| wdata | input | 32 | Write data; byte registers use bits 7:0 |
| rdata | output | 32 | Read data, combinational from the offset |
| irq | output | 1 | Pending interrupt line |

## Verification
The hardest state to reach from the ports is the end of a multi-sector command with the largest count. A count of 0 has to carry the command through 256 full sector handshakes, and any slip in the remaining-sector counter only shows at the very end. The stimulus writes count 0, issues a read command and then, for each sector, polls status until DRQ appears and drains all 128 words. It counts the sectors delivered and requires idle status right after the last one. Racing commands are reached by writing a second command in the first busy cycle and an abort code during read DRQ, then checking that the busy length, the data and the error byte are unchanged.

// File: rtl/dskreg_pkg.sv
package dskreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BSY_RD = 3'd1,
    ST_DRQ_RD = 3'd2,
    ST_DRQ_WR = 3'd3,
    ST_BSY_WR = 3'd4,
    ST_RST    = 3'd5
  } seq_st_e;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_ERR   = 3'd1;
  localparam logic [2:0] OFS_CNT   = 3'd2;
  localparam logic [2:0] OFS_LBA0  = 3'd3;
  localparam logic [2:0] OFS_LBA1  = 3'd4;
  localparam logic [2:0] OFS_LBA2  = 3'd5;
  localparam logic [2:0] OFS_DRVHD = 3'd6;
  localparam logic [2:0] OFS_CMDST = 3'd7;

  localparam logic [7:0] CMD_READ  = 8'h20;
  localparam logic [7:0] CMD_WRITE = 8'h30;

  localparam int unsigned ST_BIT_BUSY  = 7;
  localparam int unsigned ST_BIT_READY = 6;
  localparam int unsigned ST_BIT_DRQ   = 3;
  localparam int unsigned ST_BIT_ERR   = 0;
  localparam int unsigned ER_BIT_ABRT  = 2;

endpackage

// File: rtl/dskreg_regfile.sv
module dskreg_regfile
  import dskreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_cmd,
  input  logic        we_ctl,
  input  logic [2:0]  addr,
  input  logic [7:0]  wbyte,
  output logic [7:0]  sec_cnt,
  output logic [27:0] lba,
  output logic        drv_sel,
  output logic        lba_mode,
  output logic        ctl_nien,
  output logic        ctl_srst
);

  logic [7:0]  cnt_q, cnt_d;
  logic [27:0] lba_q, lba_d;
  logic        drv_q, drv_d, mode_q, mode_d;
  logic        nien_q, nien_d, srst_q, srst_d;
  logic        en_cmd, en_ctl;

  assign en_cmd = we_cmd;
  assign en_ctl = we_ctl;

  always_comb begin
    cnt_d  = cnt_q;
    lba_d  = lba_q;
    drv_d  = drv_q;
    mode_d = mode_q;
    unique case (addr)
      OFS_CNT:   cnt_d         = wbyte;
      OFS_LBA0:  lba_d[7:0]    = wbyte;
      OFS_LBA1:  lba_d[15:8]   = wbyte;
      OFS_LBA2:  lba_d[23:16]  = wbyte;
      OFS_DRVHD: begin
        lba_d[27:24] = wbyte[3:0];
        drv_d        = wbyte[4];
        mode_d       = wbyte[6];
      end
      default: ;
    endcase
    nien_d = wbyte[1];
    srst_d = wbyte[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lba_q  <= '0;
      drv_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (en_cmd) begin
      cnt_q  <= cnt_d;
      lba_q  <= lba_d;
      drv_q  <= drv_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nien_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (en_ctl) begin
      nien_q <= nien_d;
      srst_q <= srst_d;
    end
  end

  assign sec_cnt  = cnt_q;
  assign lba      = lba_q;
  assign drv_sel  = drv_q;
  assign lba_mode = mode_q;
  assign ctl_nien = nien_q;
  assign ctl_srst = srst_q;

endmodule

// File: rtl/dskreg_seq.sv
module dskreg_seq
  import dskreg_pkg::*;
#(
  parameter int unsigned SVC_DELAY = 8,
  parameter int unsigned WORDS     = 128,
  localparam int unsigned DLY_W    = (SVC_DELAY > 1) ? $clog2(SVC_DELAY) : 1,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_code,
  input  logic             data_we,
  input  logic             data_re,
  input  logic             stat_re,
  input  logic [7:0]       sec_cnt,
  input  logic             ctl_nien,
  input  logic             ctl_srst,
  output logic [7:0]       status,
  output logic [7:0]       error,
  output logic             irq,
  output logic [IDX_W-1:0] idx,
  output logic             buf_we
);

  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SVC_DELAY - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  seq_st_e          st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [8:0]       rem_q, rem_d;
  logic             abrt_q, abrt_d;
  logic             pend_q, pend_d;
  logic             sec_ev;
  logic             busy, drq;

  always_comb begin
    st_d   = st_q;
    dly_d  = dly_q;
    idx_d  = idx_q;
    rem_d  = rem_q;
    abrt_d = abrt_q;
    pend_d = pend_q;
    sec_ev = 1'b0;
    buf_we = 1'b0;
    if (stat_re) pend_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_we) begin
          abrt_d = 1'b0;
          idx_d  = '0;
          dly_d  = '0;
          rem_d  = (sec_cnt == 8'd0) ? 9'd256 : {1'b0, sec_cnt};
          if (cmd_code == CMD_READ) begin
            st_d = ST_BSY_RD;
          end else if (cmd_code == CMD_WRITE) begin
            st_d = ST_DRQ_WR;
          end else begin
            abrt_d = 1'b1;
            sec_ev = 1'b1;
          end
        end
      end
      ST_BSY_RD: begin
        if (dly_q == DLY_LAST) begin
          st_d   = ST_DRQ_RD;
          sec_ev = 1'b1;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_DRQ_RD: begin
        if (data_re) begin
          if (idx_q == IDX_LAST) begin
            idx_d = '0;
            dly_d = '0;
            if (rem_q == 9'd1) begin
              st_d = ST_IDLE;
            end else begin
              rem_d = rem_q - 1'b1;
              st_d  = ST_BSY_RD;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DRQ_WR: begin
        if (data_we) begin
          buf_we = 1'b1;
          if (idx_q == IDX_LAST) begin
            idx_d = '0;
            dly_d = '0;
            st_d  = ST_BSY_WR;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_BSY_WR: begin
        if (dly_q == DLY_LAST) begin
          sec_ev = 1'b1;
          if (rem_q == 9'd1) begin
            st_d = ST_IDLE;
          end else begin
            rem_d = rem_q - 1'b1;
            st_d  = ST_DRQ_WR;
          end
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_RST:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (sec_ev && !ctl_nien) pend_d = 1'b1;
    if (ctl_srst) begin
      st_d   = ST_RST;
      abrt_d = 1'b0;
      pend_d = 1'b0;
      idx_d  = '0;
      buf_we = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dly_q  <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      abrt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      abrt_q <= abrt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = (st_q == ST_BSY_RD) || (st_q == ST_BSY_WR) || (st_q == ST_RST);
  assign drq  = (st_q == ST_DRQ_RD) || (st_q == ST_DRQ_WR);

  always_comb begin
    status = '0;
    status[ST_BIT_BUSY]  = busy;
    status[ST_BIT_READY] = !busy;
    status[ST_BIT_DRQ]   = drq;
    status[ST_BIT_ERR]   = abrt_q;
    error = '0;
    error[ER_BIT_ABRT]   = abrt_q;
  end

  assign irq = pend_q;
  assign idx = idx_q;

endmodule

// File: rtl/dskreg_sbuf.sv
module dskreg_sbuf #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/dskreg_target.sv
module dskreg_target
  import dskreg_pkg::*;
#(
  parameter int unsigned SVC_DELAY    = 8,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned DATA_W       = 32,
  localparam int unsigned WORDS       = SECTOR_BYTES / (DATA_W / 8),
  localparam int unsigned IDX_W       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_cmd,
  input  logic              cs_ctl,
  input  logic [2:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [7:0]        sec_cnt;
  logic [27:0]       lba;
  logic              drv_sel, lba_mode, ctl_nien, ctl_srst;
  logic [7:0]        stat_w, err_w;
  logic [IDX_W-1:0]  idx;
  logic              buf_we;
  logic [DATA_W-1:0] buf_rd;
  logic              wr_cmd, rd_cmd;
  logic [7:0]        byte_rd;

  assign wr_cmd = cs_cmd && wr;
  assign rd_cmd = cs_cmd && rd;

  dskreg_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_cmd   (wr_cmd),
    .we_ctl   (cs_ctl && wr),
    .addr     (addr),
    .wbyte    (wdata[7:0]),
    .sec_cnt  (sec_cnt),
    .lba      (lba),
    .drv_sel  (drv_sel),
    .lba_mode (lba_mode),
    .ctl_nien (ctl_nien),
    .ctl_srst (ctl_srst)
  );

  dskreg_seq #(
    .SVC_DELAY (SVC_DELAY),
    .WORDS     (WORDS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (wr_cmd && (addr == OFS_CMDST)),
    .cmd_code (wdata[7:0]),
    .data_we  (wr_cmd && (addr == OFS_DATA)),
    .data_re  (rd_cmd && (addr == OFS_DATA)),
    .stat_re  (rd_cmd && (addr == OFS_CMDST)),
    .sec_cnt  (sec_cnt),
    .ctl_nien (ctl_nien),
    .ctl_srst (ctl_srst),
    .status   (stat_w),
    .error    (err_w),
    .irq      (irq),
    .idx      (idx),
    .buf_we   (buf_we)
  );

  dskreg_sbuf #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W)
  ) u_sbuf (
    .clk   (clk),
    .we    (buf_we),
    .idx   (idx),
    .wdata (wdata),
    .rdata (buf_rd)
  );

  always_comb begin
    unique case (addr)
      OFS_ERR:   byte_rd = err_w;
      OFS_CNT:   byte_rd = sec_cnt;
      OFS_LBA0:  byte_rd = lba[7:0];
      OFS_LBA1:  byte_rd = lba[15:8];
      OFS_LBA2:  byte_rd = lba[23:16];
      OFS_DRVHD: byte_rd = {1'b1, lba_mode, 1'b1, drv_sel, lba[27:24]};
      OFS_CMDST: byte_rd = stat_w;
      default:   byte_rd = 8'h00;
    endcase
  end

  always_comb begin
    if (!rd_cmd)                rdata = '0;
    else if (addr == OFS_DATA)  rdata = buf_rd;
    else                        rdata = {{(DATA_W-8){1'b0}}, byte_rd};
  end

endmodule

// File: rtl/dskreg_target_chk.sv
module dskreg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_cmd,
  input logic       wr,
  input logic       rd,
  input logic [2:0] addr,
  input logic [7:0] cmd_byte,
  input logic       nien,
  input logic       srst,
  input logic [7:0] status,
  input logic [7:0] error,
  input logic       irq
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> (!status[6] && !status[3])); // R3

  AST_WRCMD_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_cmd && wr && addr == 3'd7 && cmd_byte == 8'h30 && status == 8'h40 && !srst)
    |=> (status == 8'h48)); // R4

  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (error == 8'h04 && !status[7] && !status[3])); // R10

  AST_STAT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_cmd && rd && !wr && addr == 3'd7 && status == 8'h40 && !srst) |=> !irq); // R9

  AST_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    nien |=> !$rose(irq)); // R8

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status == 8'h80 && !irq && error == 8'h00)); // R11

endmodule

bind dskreg_target dskreg_target_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_cmd   (cs_cmd),
  .wr       (wr),
  .rd       (rd),
  .addr     (addr),
  .cmd_byte (wdata[7:0]),
  .nien     (ctl_nien),
  .srst     (ctl_srst),
  .status   (stat_w),
  .error    (err_w),
  .irq      (irq)
);

// File: tb/test_dskreg_target.sv
`timescale 1ns/1ps
module test_dskreg_target;

  localparam int DLY = 8;
  localparam int NW  = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_cmd, cs_ctl, wr, rd;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dskreg_target #(.SVC_DELAY(DLY)) i_dskreg_target (
    .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {write, offset, data byte, expected read byte}
  localparam logic [19:0] VEC [12] = '{
    {1'b1, 3'd2, 8'h05, 8'h00},
    {1'b1, 3'd3, 8'h11, 8'h00},
    {1'b1, 3'd4, 8'h22, 8'h00},
    {1'b1, 3'd5, 8'h33, 8'h00},
    {1'b1, 3'd6, 8'h5B, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h05},
    {1'b0, 3'd3, 8'h00, 8'h11},
    {1'b0, 3'd4, 8'h00, 8'h22},
    {1'b0, 3'd5, 8'h00, 8'h33},
    {1'b0, 3'd6, 8'h00, 8'hFB},
    {1'b1, 3'd6, 8'h03, 8'h00},
    {1'b0, 3'd6, 8'h00, 8'hA3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    cs_cmd = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_cmd = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    cs_ctl = 1'b1; wr = 1'b1; wdata = {24'h0, d};
    @(negedge clk);
    cs_ctl = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v, output logic iq);
    cs_cmd = 1'b1; rd = 1'b1; addr = a;
    #1;
    v  = rdata;
    iq = irq;
    @(negedge clk);
    cs_cmd = 1'b0; rd = 1'b0;
  endtask

  // polls status, returns busy cycles seen, first non-busy status and irq then
  task automatic poll(output int nbusy, output logic [31:0] st, output logic iq);
    nbusy = 0;
    for (int k = 0; k < 4 * DLY + 8; k++) begin
      rd_reg(3'd7, st, iq);
      if (st != 32'h80) break;
      nbusy++;
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int i);
    return {8'hC0 ^ 8'(s), 8'h5E, 8'(i), ~8'(i)};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic        iq;
    int          nb;
    int          bad;
    int          irqs;
    int          secs;
    rst_n = 1'b0; cs_cmd = 1'b0; cs_ctl = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd_reg(3'd7, v, iq); check("R1 status", v, 32'h40);
    rd_reg(3'd1, v, iq); check("R1 error", v, 32'h00);
    rd_reg(3'd2, v, iq); check("R1 count", v, 32'h00);
    rd_reg(3'd5, v, iq); check("R1 lba2", v, 32'h00);
    rd_reg(3'd6, v, iq); check("R1 drvhead", v, 32'hA0);

    // R2 register table
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][19]) wr_reg(VEC[i][18:16], {24'h0, VEC[i][15:8]});
      else begin
        rd_reg(VEC[i][18:16], v, iq);
        check("R2 readback", v, {24'h0, VEC[i][7:0]});
      end
    end

    // R4, R5, R8, R9: one-sector write
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd7, 32'h30);
    rd_reg(3'd7, v, iq); check("R4 drq at once", v, 32'h48);
    for (int i = 0; i < NW; i++) wr_reg(3'd0, pat(0, i));
    poll(nb, v, iq);
    check("R5 write commit busy", nb, DLY);
    check("R5 idle after write", v, 32'h40);
    check("R8 irq after write sector", {31'h0, iq}, 32'h1);
    check("R9 irq cleared by status read", {31'h0, irq}, 32'h0);

    // R6 stray data write in idle is ignored
    wr_reg(3'd0, 32'hDEADBEEF);

    // R3, R6: one-sector read
    wr_reg(3'd7, 32'h20);
    poll(nb, v, iq);
    check("R3 read busy cycles", nb, DLY);
    check("R3 drq after busy", v, 32'h48);
    check("R8 irq on read ready", {31'h0, iq}, 32'h1);
    bad = 0;
    for (int i = 0; i < NW; i++) begin
      rd_reg(3'd0, v, iq);
      if (v !== pat(0, i)) bad++;
    end
    check("R6 read data matches", bad, 0);
    rd_reg(3'd7, v, iq); check("R5 drq drops after 128 reads", v, 32'h40);

    // R12: command while busy and abort code while in read DRQ are ignored
    wr_reg(3'd7, 32'h20);
    wr_reg(3'd7, 32'h30);
    poll(nb, v, iq);
    check("R12 busy unchanged by second cmd", nb, DLY - 1);
    check("R12 still read drq", v, 32'h48);
    wr_reg(3'd7, 32'h99);
    rd_reg(3'd1, v, iq); check("R12 no abort in drq", v, 32'h00);
    bad = 0;
    for (int i = 0; i < NW; i++) begin
      rd_reg(3'd0, v, iq);
      if (v !== pat(0, i)) bad++;
    end
    check("R12 data intact", bad, 0);
    rd_reg(3'd7, v, iq); check("R12 idle after", v, 32'h40);

    // R7: two-sector write, one irq each
    wr_reg(3'd2, 32'h2);
    wr_reg(3'd7, 32'h30);
    irqs = 0;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < NW; i++) wr_reg(3'd0, pat(s + 1, i));
      poll(nb, v, iq);
      if (iq) irqs++;
      check("R7 per-sector busy", nb, DLY);
      check("R7 status after sector", v, (s == 0) ? 32'h48 : 32'h40);
    end
    check("R8 one irq per sector", irqs, 2);

    // R7: count 0 read runs 256 sectors of the last written data
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd7, 32'h20);
    secs = 0;
    bad = 0;
    for (int s = 0; s < 256; s++) begin
      poll(nb, v, iq);
      if (v == 32'h48 && nb == DLY) secs++;
      for (int i = 0; i < NW; i++) begin
        rd_reg(3'd0, v, iq);
        if (v !== pat(2, i)) bad++;
      end
    end
    check("R7 256 sectors for count 0", secs, 256);
    check("R6 data across 256 sectors", bad, 0);
    rd_reg(3'd7, v, iq); check("R7 idle after last sector", v, 32'h40);

    // R10 abort
    wr_reg(3'd7, 32'h99);
    rd_reg(3'd7, v, iq);
    check("R10 abort status", v, 32'h41);
    check("R10 abort irq", {31'h0, iq}, 32'h1);
    rd_reg(3'd1, v, iq); check("R10 abort error", v, 32'h04);

    // R8 masked
    wr_ctl(8'h02);
    wr_reg(3'd7, 32'hEE);
    @(negedge clk);
    check("R8 masked irq", {31'h0, irq}, 32'h0);
    rd_reg(3'd7, v, iq); check("R10 masked abort status", v, 32'h41);
    wr_ctl(8'h00);

    // R10 error cleared by accepted command
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd7, 32'h30);
    rd_reg(3'd1, v, iq); check("R10 error cleared", v, 32'h00);

    // R11 soft reset in write DRQ
    wr_ctl(8'h04);
    @(negedge clk);
    rd_reg(3'd7, v, iq); check("R11 reset forces busy, drq cleared", v, 32'h80);
    wr_ctl(8'h00);
    @(negedge clk);
    rd_reg(3'd7, v, iq); check("R11 ready after release", v, 32'h40);

    // R11 soft reset clears error and irq
    wr_reg(3'd7, 32'h77);
    wr_ctl(8'h04);
    @(negedge clk);
    check("R11 irq cleared", {31'h0, irq}, 32'h0);
    rd_reg(3'd1, v, iq); check("R11 error cleared", v, 32'h00);
    wr_ctl(8'h00);
    @(negedge clk);
    rd_reg(3'd7, v, iq); check("R11 status after release", v, 32'h40);

    finish_run();
  end

endmodule